// File: doc/BRIEF.md
# Display Test Pattern Generator

This block sits in a display output path and, when enabled, replaces the incoming video with a generated test image. An external timing generator supplies a pixel-valid strobe together with start-of-frame and start-of-line markers. The block counts pixel positions from these markers. It can draw alternating colour bars in either direction, a grid of eight coloured squares in RGB or in one of two YCbCr forms, single or dual gradient ramps, or a solid colour. With the generator disabled, or outside the programmed active area, the video passes through unchanged.

Software writes settings into a shadow copy over a simple write port. The shadow copy moves into the working set at the next start-of-frame. A pending flag shows that written settings are still waiting, and a blanked flag shows that the generator owns the screen with nothing left to apply. Generated components are cut to 6, 8, 10 or 12 bits and returned right-aligned. Passthrough video keeps all 16 bits. Every output appears one clock after the pixel strobe that produced it.

Top module: `tpg_top`

## Requirements
- R1: A write (`wr_en` high) updates the shadow register at `wr_addr`, and `cfg_pending` reads 1 from the next clock. Register layout:
  - Address 0 is control: bit0 enable, bits3:1 mode, bits6:4 depth code, bit7 limited range, bits11:8 horizontal cell exponent, bits15:12 vertical cell exponent.
  - Address 1 is the active area: width in bits15:0, height in bits31:16.
  - Address 2 is the horizontal offset in bits15:0.
  - Addresses 3, 4 and 5 are the red/Cr, green/Y and blue/Cb colours: colour0 in bits15:0, colour1 in bits31:16.
  - Address 6 is the ramps: second-ramp start in bits15:0, first step exponent in bits19:16, second step exponent in bits23:20.
- R2: The shadow set is copied to the working set on a cycle with `sof` high, and `cfg_pending` clears after that edge. The pixel on that same `sof` cycle already uses the copied settings. A write made in the `sof` cycle stays pending and only takes effect at the following `sof`.
- R3: `blanked` is 1 exactly when the working enable bit is 1 and `cfg_pending` is 0.
- R4: The video passes through with all 16 bits unchanged in two cases: when the working enable is 0, or when the pixel lies outside the active area (x ≥ width or y ≥ height). Writing zero to the control register therefore returns the block to passthrough after the next `sof`.
- R5: Pixel position is counted from the markers:
  - `sof` gives x=0, y=0.
  - `sol` alone gives x=0 and y+1.
  - Any other valid pixel gives x+1.
  
  The horizontal cell index is ((x − offset) mod 2^16) >> horizontal exponent. The vertical cell index is y >> vertical exponent.
- R6: Mode 0 draws vertical bars and mode 1 draws horizontal bars. Each picks colour1 when the bit-0 of the horizontal (or vertical) cell index is 1, and colour0 otherwise. The low 4 bits of every colour component are stored as zero. Loading the same value into both colours gives a solid colour.
- R7: Mode 2 (RGB squares) uses idx = (horizontal cell + vertical cell) mod 8. Red is on when idx bit2 is set, green when bit1 is set, and blue when bit0 is set. The 8-bit level is 255 when on and 0 when off in full range. In limited range it is 235 when on and 16 when off. The level is placed in bits 15:8.
- R8: Modes 3 and 4 (YCbCr squares) take the same R, G and B levels and compute:
  - Y = (kr·R + kg·G + kb·B) >> 8, with weights (77, 150, 29) for mode 3 and (54, 183, 19) for mode 4.
  - Cb = 128 + floor((B − Y)/2).
  - Cr = 128 + floor((R − Y)/2).
  
  Cr goes on the red output, Y on the green output and Cb on the blue output, each in bits 15:8.
- R9: Mode 5 (single ramp) outputs (horizontal cell << first step) mod 2^16 on all three components. Mode 6 (dual ramp) does the same on even vertical cells. On odd vertical cells it outputs (start + (horizontal cell << second step)) mod 2^16.
- R10: Depth codes 0, 1, 2 and 3 select 6, 8, 10 and 12 bits, and any other code selects 8. A generated component is output as its 16-bit value shifted right by (16 − bits). Mode 7 outputs colour0.
- R11: `out_valid` is `pix_valid` delayed by one clock. The output pixel is registered one clock after its strobe and holds while `pix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel strobe from timing generator |
| sof | input | 1 | Start of frame, marks the first pixel of a frame |
| sol | input | 1 | Start of line, marks the first pixel of a line |
| vid_r | input | 16 | Incoming video red/Cr |
| vid_g | input | 16 | Incoming video green/Y |
| vid_b | input | 16 | Incoming video blue/Cb |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 16 | Output red/Cr |
| out_g | output | 16 | Output green/Y |
| out_b | output | 16 | Output blue/Cb |
| cfg_pending | output | 1 | Written settings not yet applied |
| blanked | output | 1 | Generator enabled with nothing pending |

## Verification
The two functions that can coincide are a register write and the start-of-frame commit. The bench makes them collide by issuing a control write in the very cycle that carries `sof`. It then checks three things:
- the frame that starts there uses the settings already waiting in the shadow copy;
- `cfg_pending` stays set through that frame and `blanked` stays low;
- the written value first shows on the following frame.

The reference model applies the commit before the write at each edge and compares every output on every clock.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int CW = 16;   // component width
    localparam int PW = 16;   // position width
    localparam int DW = 32;   // register data width
    localparam int AW = 3;    // register address width

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_AREA = 3'd1;
    localparam logic [AW-1:0] A_OFFS = 3'd2;
    localparam logic [AW-1:0] A_COLR = 3'd3;
    localparam logic [AW-1:0] A_COLG = 3'd4;
    localparam logic [AW-1:0] A_COLB = 3'd5;
    localparam logic [AW-1:0] A_RAMP = 3'd6;

    localparam int ZBITS = 4;  // hardwired-zero low colour bits

    typedef enum logic [2:0] {
        M_VBAR   = 3'd0,
        M_HBAR   = 3'd1,
        M_SQ_RGB = 3'd2,
        M_SQ_601 = 3'd3,
        M_SQ_709 = 3'd4,
        M_RAMP1  = 3'd5,
        M_RAMP2  = 3'd6,
        M_RSVD   = 3'd7
    } mode_e;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } pix_t;

    typedef struct packed {
        logic          en;
        mode_e         mode;
        logic [2:0]    depth;
        logic          lim;
        logic [3:0]    hexp;
        logic [3:0]    vexp;
        logic [PW-1:0] width;
        logic [PW-1:0] height;
        logic [PW-1:0] xoff;
        pix_t          c0;
        pix_t          c1;
        logic [CW-1:0] rstart;
        logic [3:0]    inc0;
        logic [3:0]    inc1;
    } cfg_t;

    // right shift that keeps the top N bits of a 16-bit component
    function automatic logic [4:0] depth_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd10;
            3'd1:    return 5'd8;
            3'd2:    return 5'd6;
            3'd3:    return 5'd4;
            default: return 5'd8;
        endcase
    endfunction

    function automatic logic [CW-1:0] msb_colour(input logic [CW-1:0] v);
        return {v[CW-1:ZBITS], {ZBITS{1'b0}}};
    endfunction

    // one square of the eight-colour grid, RGB or YCbCr
    function automatic pix_t square_pix(input logic [2:0] idx, input logic lim,
                                        input mode_e m);
        int hi, lo, r8, g8, b8, kr, kg, kb, y, cb, cr;
        pix_t p;
        hi = lim ? 235 : 255;
        lo = lim ? 16 : 0;
        r8 = idx[2] ? hi : lo;
        g8 = idx[1] ? hi : lo;
        b8 = idx[0] ? hi : lo;
        if (m == M_SQ_RGB) begin
            p.r = {8'(r8), 8'h00};
            p.g = {8'(g8), 8'h00};
            p.b = {8'(b8), 8'h00};
        end else begin
            kr = (m == M_SQ_709) ? 54  : 77;
            kg = (m == M_SQ_709) ? 183 : 150;
            kb = (m == M_SQ_709) ? 19  : 29;
            y  = (kr * r8 + kg * g8 + kb * b8) >>> 8;
            cb = 128 + ((b8 - y) >>> 1);
            cr = 128 + ((r8 - y) >>> 1);
            p.r = {8'(cr), 8'h00};
            p.g = {8'(y),  8'h00};
            p.b = {8'(cb), 8'h00};
        end
        return p;
    endfunction

endpackage

// File: rtl/tpg_cfg.sv
module tpg_cfg
    import tpg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          sof,
    output cfg_t          cfg_use,
    output logic          act_en,
    output logic          pending
);

    cfg_t shadow_q, shadow_d, active_q;
    logic pend_q;

    always_comb begin
        shadow_d = shadow_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    shadow_d.en    = wr_data[0];
                    shadow_d.mode  = mode_e'(wr_data[3:1]);
                    shadow_d.depth = wr_data[6:4];
                    shadow_d.lim   = wr_data[7];
                    shadow_d.hexp  = wr_data[11:8];
                    shadow_d.vexp  = wr_data[15:12];
                end
                A_AREA: begin
                    shadow_d.width  = wr_data[15:0];
                    shadow_d.height = wr_data[31:16];
                end
                A_OFFS: shadow_d.xoff = wr_data[15:0];
                A_COLR: begin
                    shadow_d.c0.r = msb_colour(wr_data[15:0]);
                    shadow_d.c1.r = msb_colour(wr_data[31:16]);
                end
                A_COLG: begin
                    shadow_d.c0.g = msb_colour(wr_data[15:0]);
                    shadow_d.c1.g = msb_colour(wr_data[31:16]);
                end
                A_COLB: begin
                    shadow_d.c0.b = msb_colour(wr_data[15:0]);
                    shadow_d.c1.b = msb_colour(wr_data[31:16]);
                end
                A_RAMP: begin
                    shadow_d.rstart = wr_data[15:0];
                    shadow_d.inc0   = wr_data[19:16];
                    shadow_d.inc1   = wr_data[23:20];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            shadow_q <= shadow_d;
            if (sof) active_q <= shadow_q;
            if (wr_en)    pend_q <= 1'b1;
            else if (sof) pend_q <= 1'b0;
        end
    end

    // the frame's first pixel already sees the committed set
    assign cfg_use = (sof && pend_q) ? shadow_q : active_q;
    assign act_en  = active_q.en;
    assign pending = pend_q;

    p_write_pends_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> pend_q);
    p_commit_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (sof && !wr_en) |=> !pend_q);
    p_commit_copies_r2: assert property (@(posedge clk) disable iff (rst)
        sof |=> (active_q == $past(shadow_q)));
    p_active_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !sof |=> $stable(active_q));

endmodule

// File: rtl/tpg_pos.sv
module tpg_pos
    import tpg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_valid,
    input  logic          sof,
    input  logic          sol,
    output logic [PW-1:0] px,
    output logic [PW-1:0] py
);

    logic [PW-1:0] x_q, y_q;

    always_comb begin
        px = (sof || sol) ? '0 : x_q + 1'b1;
        if (sof)      py = '0;
        else if (sol) py = y_q + 1'b1;
        else          py = y_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (pix_valid) begin
            x_q <= px;
            y_q <= py;
        end
    end

    p_frame_origin_r5: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && sof) |=> (x_q == '0 && y_q == '0));

endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern
    import tpg_pkg::*;
(
    input  cfg_t          cfg,
    input  logic [PW-1:0] px,
    input  logic [PW-1:0] py,
    input  pix_t          vid,
    output pix_t          pix,
    output logic          gen
);

    logic [PW-1:0] hx, hcell, vcell;
    logic [2:0]    sq_idx;
    logic [CW-1:0] ramp0, ramp1;
    logic [4:0]    sh;
    pix_t          raw, scaled;

    always_comb begin
        hx     = px - cfg.xoff;
        hcell  = hx >> cfg.hexp;
        vcell  = py >> cfg.vexp;
        sq_idx = 3'(hcell + vcell);
        ramp0  = CW'(hcell << cfg.inc0);
        ramp1  = cfg.rstart + CW'(hcell << cfg.inc1);
        case (cfg.mode)
            M_VBAR:   raw = hcell[0] ? cfg.c1 : cfg.c0;
            M_HBAR:   raw = vcell[0] ? cfg.c1 : cfg.c0;
            M_SQ_RGB, M_SQ_601, M_SQ_709:
                      raw = square_pix(sq_idx, cfg.lim, cfg.mode);
            M_RAMP1:  raw = '{r: ramp0, g: ramp0, b: ramp0};
            M_RAMP2:  raw = vcell[0] ? '{r: ramp1, g: ramp1, b: ramp1}
                                     : '{r: ramp0, g: ramp0, b: ramp0};
            default:  raw = cfg.c0;
        endcase
        sh       = depth_shift(cfg.depth);
        scaled.r = raw.r >> sh;
        scaled.g = raw.g >> sh;
        scaled.b = raw.b >> sh;
        gen      = cfg.en && (px < cfg.width) && (py < cfg.height);
        pix      = gen ? scaled : vid;
    end

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          pix_valid,
    input  logic          sof,
    input  logic          sol,
    input  logic [15:0]   vid_r,
    input  logic [15:0]   vid_g,
    input  logic [15:0]   vid_b,
    output logic          out_valid,
    output logic [15:0]   out_r,
    output logic [15:0]   out_g,
    output logic [15:0]   out_b,
    output logic          cfg_pending,
    output logic          blanked
);

    cfg_t          cfg_use;
    logic          act_en;
    logic [PW-1:0] px, py;
    pix_t          vid, pix, out_q;
    logic          gen;
    logic          valid_q;

    assign vid = '{r: vid_r, g: vid_g, b: vid_b};

    tpg_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sof(sof), .cfg_use(cfg_use),
        .act_en(act_en), .pending(cfg_pending)
    );

    tpg_pos u_pos (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .sof(sof),
        .sol(sol), .px(px), .py(py)
    );

    tpg_pattern u_pat (
        .cfg(cfg_use), .px(px), .py(py), .vid(vid), .pix(pix), .gen(gen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= pix_valid;
            if (pix_valid) out_q <= pix;
        end
    end

    assign out_valid = valid_q;
    assign out_r     = out_q.r;
    assign out_g     = out_q.g;
    assign out_b     = out_q.b;
    assign blanked   = act_en && !cfg_pending;

    p_valid_rise_r11: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);
    p_valid_fall_r11: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
    p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !gen) |=> (out_r == $past(vid_r) && out_g == $past(vid_g)
                                 && out_b == $past(vid_b)));
    p_depth6_r10: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && gen && cfg_use.depth == 3'd0) |=>
            (out_r[15:6] == '0 && out_g[15:6] == '0 && out_b[15:6] == '0));

endmodule

// File: tb/tpg_top_bench.sv
module tpg_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pix_valid = 1'b0, sof = 1'b0, sol = 1'b0;
    logic [15:0] vid_r = '0, vid_g = '0, vid_b = '0;
    logic        out_valid, cfg_pending, blanked;
    logic [15:0] out_r, out_g, out_b;

    always #4 clk = ~clk;  // 125 MHz

    tpg_top u_tpg_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_valid(pix_valid), .sof(sof), .sol(sol),
        .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .cfg_pending(cfg_pending), .blanked(blanked)
    );

    int checks = 0, failures = 0;
    string tag = "R11 reset";
    logic armed = 1'b0;

    // reference model state
    logic [31:0] sh[7], act[7], use_w[7];
    bit  m_pend;
    int  m_x, m_y;
    bit  e_valid;
    int  e_r, e_g, e_b;

    task automatic check(input string t, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", t, act_v, exp_v);
        end
    endtask

    function automatic int square(input int idx, input int lim, input int mode, input int comp);
        int hi, lo, r8, g8, b8, kr, kg, kb, y, cb, cr;
        hi = lim ? 235 : 255;
        lo = lim ? 16 : 0;
        r8 = (idx & 4) ? hi : lo;
        g8 = (idx & 2) ? hi : lo;
        b8 = (idx & 1) ? hi : lo;
        if (mode == 2) return ((comp == 0) ? r8 : (comp == 1) ? g8 : b8) * 256;
        if (mode == 3) begin kr = 77; kg = 150; kb = 29; end
        else begin kr = 54; kg = 183; kb = 19; end
        y  = (kr * r8 + kg * g8 + kb * b8) / 256;
        cb = 128 + ((b8 - y) >>> 1);
        cr = 128 + ((r8 - y) >>> 1);
        return ((comp == 0) ? cr : (comp == 1) ? y : cb) * 256;
    endfunction

    function automatic int model_comp(input int px, input int py, input int comp, input int vid);
        int mode, dc, bits, hc, vc, c0, c1, v, sel;
        if (use_w[0][0] == 1'b0 || px >= int'(use_w[1][15:0]) || py >= int'(use_w[1][31:16]))
            return vid;
        mode = int'(use_w[0][3:1]);
        dc   = int'(use_w[0][6:4]);
        bits = (dc == 0) ? 6 : (dc == 1) ? 8 : (dc == 2) ? 10 : (dc == 3) ? 12 : 8;
        hc   = ((px - int'(use_w[2][15:0])) & 16'hFFFF) >> use_w[0][11:8];
        vc   = py >> use_w[0][15:12];
        c0   = int'(use_w[3 + comp][15:0]);
        c1   = int'(use_w[3 + comp][31:16]);
        sel  = 0;
        case (mode)
            0: v = (hc % 2) ? c1 : c0;
            1: v = (vc % 2) ? c1 : c0;
            2, 3, 4: v = square((hc + vc) % 8, int'(use_w[0][7]), mode, comp);
            5: v = (hc << use_w[6][19:16]) & 16'hFFFF;
            6: if (vc % 2) v = (int'(use_w[6][15:0]) + (hc << use_w[6][23:20])) & 16'hFFFF;
               else        v = (hc << use_w[6][19:16]) & 16'hFFFF;
            default: v = c0;
        endcase
        if (sel != 0) v = 0;
        return v >> (16 - bits);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 7; i++) begin sh[i] = '0; act[i] = '0; end
            m_pend = 0; m_x = 0; m_y = 0; e_valid = 0; e_r = 0; e_g = 0; e_b = 0;
        end else begin
            for (int i = 0; i < 7; i++) use_w[i] = (sof && m_pend) ? sh[i] : act[i];
            e_valid = pix_valid;
            if (pix_valid) begin
                int px, py;
                px = (sof || sol) ? 0 : (m_x + 1) & 16'hFFFF;
                py = sof ? 0 : sol ? (m_y + 1) & 16'hFFFF : m_y;
                e_r = model_comp(px, py, 0, int'(vid_r));
                e_g = model_comp(px, py, 1, int'(vid_g));
                e_b = model_comp(px, py, 2, int'(vid_b));
                m_x = px; m_y = py;
            end
            if (sof) for (int i = 0; i < 7; i++) act[i] = sh[i];
            if (wr_en && wr_addr != 3'd7)
                sh[wr_addr] = (wr_addr >= 3 && wr_addr <= 5) ? (wr_data & 32'hFFF0FFF0) : wr_data;
            if (wr_en) m_pend = 1; else if (sof) m_pend = 0;
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            check({tag, " out_valid"}, int'(out_valid), int'(e_valid));
            check({tag, " out_r"}, int'(out_r), e_r);
            check({tag, " out_g"}, int'(out_g), e_g);
            check({tag, " out_b"}, int'(out_b), e_b);
            check("R1 pending", int'(cfg_pending), int'(m_pend));
            check("R3 blanked", int'(blanked), int'(act[0][0] && !m_pend));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic frame(input int lines, input int ppl, input bit hit,
                         input logic [2:0] a, input logic [31:0] d);
        for (int l = 0; l < lines; l++) begin
            for (int p = 0; p < ppl; p++) begin
                @(negedge clk);
                if (p == 5) begin
                    pix_valid = 1'b0; sof = 1'b0; sol = 1'b0; wr_en = 1'b0;
                    @(negedge clk);
                end
                pix_valid = 1'b1;
                sof   = (l == 0 && p == 0);
                sol   = (p == 0);
                vid_r = 16'(l * 1000 + p * 3 + 1);
                vid_g = 16'(l * 77 + p * 11 + 2);
                vid_b = 16'(16'hF000 ^ (l * 256 + p));
                wr_en = hit && sof; wr_addr = a; wr_data = d;
            end
        end
        @(negedge clk);
        pix_valid = 1'b0; sof = 1'b0; sol = 1'b0; wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ctrl_frame(input string t, input logic [31:0] c);
        wr(3'd0, c);
        tag = t;
        frame(6, 24, 1'b0, 3'd0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset out_valid", int'(out_valid), 0);
        check("R3 reset blanked", int'(blanked), 0);
        check("R1 reset pending", int'(cfg_pending), 0);
        armed = 1'b1;

        tag = "R4 disabled";
        frame(4, 20, 1'b0, 3'd0, 32'd0);

        // area 20 x 5, colours
        wr(3'd1, {16'd5, 16'd20});
        wr(3'd3, {16'hABCD, 16'h1237});
        wr(3'd4, {16'h5555, 16'hFFFF});
        wr(3'd5, {16'h800F, 16'h0001});
        check("R1 pending after write", int'(cfg_pending), 1);
        ctrl_frame("R6 vbar", 32'h0000_0131);       // vbar, 12 bit, hexp 1
        ctrl_frame("R6 hbar", 32'h0000_1023);       // hbar, 10 bit, vexp 1
        wr(3'd2, 32'd3);
        ctrl_frame("R5 offset", 32'h0000_0211);     // vbar, 8 bit, hexp 2
        wr(3'd2, 32'd0);
        ctrl_frame("R7 rgb full", 32'h0000_1215);
        ctrl_frame("R7 rgb limited", 32'h0000_01A5);
        ctrl_frame("R8 ycc 601", 32'h0000_1017);
        ctrl_frame("R8 ycc 709", 32'h0000_0139);
        wr(3'd6, 32'h0000_0000 | (32'd8 << 16));
        ctrl_frame("R9 single ramp", 32'h0000_001B);
        wr(3'd6, (32'd8 << 20) | (32'd6 << 16) | 32'h6000);
        ctrl_frame("R9 dual ramp", 32'h0000_002D);
        ctrl_frame("R10 depth 6", 32'h0000_0101);
        ctrl_frame("R10 depth fallback", 32'h0000_0171);
        ctrl_frame("R10 reserved mode", 32'h0000_003F);
        // solid colour: equal colour0 and colour1
        wr(3'd3, {16'h4321, 16'h4321});
        ctrl_frame("R6 solid", 32'h0000_0033);

        // write colliding with start of frame
        wr(3'd0, 32'h0000_0015);
        tag = "R2 collide";
        frame(4, 20, 1'b1, 3'd0, 32'h0000_0131);
        check("R2 pending after collide", int'(cfg_pending), 1);
        check("R3 blanked after collide", int'(blanked), 0);
        tag = "R2 next frame";
        frame(4, 20, 1'b0, 3'd0, 32'd0);
        check("R2 pending cleared", int'(cfg_pending), 0);
        check("R3 blanked set", int'(blanked), 1);

        // zeros back to passthrough
        wr(3'd3, 32'd0); wr(3'd4, 32'd0); wr(3'd5, 32'd0); wr(3'd6, 32'd0);
        ctrl_frame("R4 zeroed", 32'h0000_0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule